// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master transaction from a single packed 32-bit command word. Once accepted, the command drives a START, an address phase in 7-bit or 10-bit form, an optional start-byte (master code) preamble, and a counted run of data bytes in one direction. The transaction then either ends with STOP or leaves the bus held, so that the next command opens with a repeated START.

The block does not toggle SCL or SDA. It issues byte-level operations (START, write byte, read byte, STOP) to a separate line engine through a request/done handshake. The engine reports the slave's acknowledge bit, the received byte, arbitration loss and unexpected bus conditions. Progress and outcome are published in a 20-bit status word that carries a 3-bit abort cause. One-cycle event pulses mark each way a transaction can end.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the status word reads 0x00003: operation field (bits 1:0) = 3 meaning no operation yet, state (bits 3:2) = 0 idle, cause (bits 6:4) = 0, count (bits 19:9) = 0. No engine request is raised.
- R2: Command fields are: bit 0 direction (0 write, 1 read), bits 7:1 seven-bit address, bits 10:8 upper three bits of a 10-bit address, bit 11 start-byte enable, bits 13:12 address mode (2 = 10-bit, anything else = 7-bit), bit 14 STOP enable, bits 25:15 length. A 7-bit write issues START, then the address byte {addr7, dir}, then `length` write-byte operations. Each write byte carries `wr_data`, and each acknowledged byte gives one `wr_take` pulse. The status count (bits 19:9) equals the number of acknowledged bytes.
- R3: In 10-bit mode the first address byte is {11110, addr[9:8], dir} and the second is addr[7:0]. Here addr[9:7] comes from bits 10:8 and addr[6:0] from bits 7:1. Both bytes must be acknowledged.
- R4: A read issues `length` read-byte operations. `eng_ack_out` is 1 (send ACK) for every byte except the last, which gets 0 (NACK). Each received byte appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R5: With STOP enable set, a successful transaction ends with a STOP operation. The state becomes 2 (done OK) and `ev_done_stop` pulses once.
- R6: With STOP enable clear, no STOP is issued. The state becomes 2 and `ev_done_nostop` pulses, leaving the bus held. The next command starts with a START operation that acts as a repeated start.
- R7: A NACK on any address byte aborts with cause 0. A NACK on a written data byte aborts with cause 1; that byte is not counted. Either abort issues STOP, then sets state 3 (aborted), with no done event.
- R8: With start-byte enable set, START is followed by a write of 0x01, which must be NACKed, then a second START before the address. If the master code is ACKed, the transaction aborts with cause 2 and issues STOP.
- R9: Arbitration loss reported with any completed operation aborts at once with cause 3. `ev_arb_lost` pulses and no further operation, not even STOP, is requested.
- R10: `eng_bus_err` (unexpected START/STOP) during a transaction aborts at once with cause 4. `ev_bus_err` pulses and the engine request drops.
- R11: A command with any of bits 31:26 set asks for more than 2047 bytes. It is rejected with state 3 and cause 6 (overflow), and no bus operation is issued.
- R12: A command presented while the state is 1 (in progress) is ignored. The running transaction and its status are unaffected.
- R13: A length of 0 goes from the acknowledged address straight to completion, with no data operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 32 | Packed transaction command |
| status | output | 20 | Operation, state, abort cause, receive type (0), byte count |
| ev_done_stop | output | 1 | Pulse: transaction done, STOP sent |
| ev_done_nostop | output | 1 | Pulse: transaction done, bus held |
| ev_arb_lost | output | 1 | Pulse: arbitration lost |
| ev_bus_err | output | 1 | Pulse: unexpected bus condition |
| wr_data | input | 8 | Next byte to transmit |
| wr_take | output | 1 | Pulse: one transmit byte consumed |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` updated |
| eng_req | output | 1 | Operation request to line engine (held until done) |
| eng_op | output | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| eng_wdata | output | 8 | Byte for a write operation |
| eng_ack_out | output | 1 | Read operation: 1 send ACK, 0 send NACK |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_rx_ack | input | 1 | Write operation: 1 slave acknowledged |
| eng_rdata | input | 8 | Read operation: received byte |
| eng_arb_lost | input | 1 | With `eng_done`: arbitration was lost |
| eng_bus_err | input | 1 | Unexpected START/STOP seen |

## Verification
The hardest states to reach are the aborts that depend on where in the operation sequence a fault lands. Examples are a NACK on the third written byte rather than the address, an ACK to the master code, or arbitration loss mid-data. They cannot be forced from the command word alone. The bench therefore models the line engine as a scripted responder whose acknowledge and arbitration answers are indexed by operation number, so each test plants the fault at an exact step. It then checks the logged operation stream and the status fields. A bus error is injected asynchronously to the handshake, once the operation log shows the data phase has begun.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  output logic [19:0] status,
  output logic        ev_done_stop,
  output logic        ev_done_nostop,
  output logic        ev_arb_lost,
  output logic        ev_bus_err,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_wdata,
  output logic        eng_ack_out,
  input  logic        eng_done,
  input  logic        eng_rx_ack,
  input  logic [7:0]  eng_rdata,
  input  logic        eng_arb_lost,
  input  logic        eng_bus_err
);
  localparam int LEN_W = 11;
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_MCODE, S_RSTART, S_ADR1, S_ADR2, S_DATA, S_STOP} st_t;
  st_t st;

  logic dir, ten, sben, stopen, abort_pend;
  logic [6:0] a7;
  logic [2:0] ea;
  logic [LEN_W-1:0] len, cnt;
  logic [1:0] op_f, state_f;
  logic [2:0] cause;

  wire busy      = state_f == 2'd1;
  wire ovf       = |cmd_word[31:26];
  wire last_byte = LEN_W'(cnt + 1'b1) == len;
  wire step      = eng_done && !eng_arb_lost && !eng_bus_err && st != S_IDLE;
  wire addr_end  = (st == S_ADR2 || (st == S_ADR1 && !ten)) && eng_rx_ack;
  wire data_end  = st == S_DATA && (dir || eng_rx_ack) && last_byte;
  wire finish    = step && ((addr_end && len == '0) || data_end);

  assign status  = {cnt, 2'b00, cause, state_f, op_f};
  assign eng_req = st != S_IDLE;
  assign eng_ack_out = !last_byte;

  always_comb begin
    eng_op    = OP_START;
    eng_wdata = 8'h00;
    case (st)
      S_MCODE: begin eng_op = OP_WR; eng_wdata = 8'h01; end
      S_ADR1:  begin eng_op = OP_WR; eng_wdata = ten ? {5'b11110, ea[2:1], dir} : {a7, dir}; end
      S_ADR2:  begin eng_op = OP_WR; eng_wdata = {ea[0], a7}; end
      S_DATA:  begin eng_op = dir ? OP_RD : OP_WR; eng_wdata = wr_data; end
      S_STOP:  eng_op = OP_STOP;
      default: eng_op = OP_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dir <= 1'b0; ten <= 1'b0; sben <= 1'b0; stopen <= 1'b0;
      abort_pend <= 1'b0; a7 <= '0; ea <= '0; len <= '0; cnt <= '0;
      op_f <= 2'b11; state_f <= 2'd0; cause <= 3'd0;
      ev_done_stop <= 1'b0; ev_done_nostop <= 1'b0; ev_arb_lost <= 1'b0; ev_bus_err <= 1'b0;
      wr_take <= 1'b0; rx_valid <= 1'b0; rx_data <= 8'h00;
    end else begin
      ev_done_stop <= 1'b0; ev_done_nostop <= 1'b0; ev_arb_lost <= 1'b0; ev_bus_err <= 1'b0;
      wr_take <= 1'b0; rx_valid <= 1'b0;
      if (cmd_valid && !busy) begin
        op_f <= {1'b0, cmd_word[0]};
        cnt <= '0;
        abort_pend <= 1'b0;
        if (ovf) begin
          state_f <= 2'd3; cause <= 3'd6;
        end else begin
          state_f <= 2'd1; cause <= 3'd0; st <= S_START;
          dir <= cmd_word[0]; a7 <= cmd_word[7:1]; ea <= cmd_word[10:8];
          sben <= cmd_word[11]; ten <= cmd_word[13:12] == 2'd2;
          stopen <= cmd_word[14]; len <= cmd_word[25:15];
        end
      end else if (st != S_IDLE) begin
        if (eng_bus_err) begin
          st <= S_IDLE; state_f <= 2'd3; cause <= 3'd4; ev_bus_err <= 1'b1;
        end else if (eng_done && eng_arb_lost) begin
          st <= S_IDLE; state_f <= 2'd3; cause <= 3'd3; ev_arb_lost <= 1'b1;
        end else if (eng_done) begin
          if (st == S_DATA && (dir || eng_rx_ack)) begin
            cnt <= cnt + 1'b1;
            rx_valid <= dir;
            wr_take <= !dir;
            if (dir) rx_data <= eng_rdata;
          end
          if (finish) begin
            if (stopen) st <= S_STOP;
            else begin st <= S_IDLE; state_f <= 2'd2; ev_done_nostop <= 1'b1; end
          end else begin
            case (st)
              S_START:  st <= sben ? S_MCODE : S_ADR1;
              S_MCODE:  if (eng_rx_ack) begin cause <= 3'd2; abort_pend <= 1'b1; st <= S_STOP; end
                        else st <= S_RSTART;
              S_RSTART: st <= S_ADR1;
              S_ADR1:   if (!eng_rx_ack) begin cause <= 3'd0; abort_pend <= 1'b1; st <= S_STOP; end
                        else st <= ten ? S_ADR2 : S_DATA;
              S_ADR2:   if (!eng_rx_ack) begin cause <= 3'd0; abort_pend <= 1'b1; st <= S_STOP; end
                        else st <= S_DATA;
              S_DATA:   if (!dir && !eng_rx_ack) begin cause <= 3'd1; abort_pend <= 1'b1; st <= S_STOP; end
              S_STOP:   begin
                          st <= S_IDLE;
                          state_f <= abort_pend ? 2'd3 : 2'd2;
                          ev_done_stop <= !abort_pend;
                        end
              default:  st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_req_only_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> status[3:2] == 2'd1);
  p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'd1 && cmd_valid && !eng_done && !eng_bus_err) |=> $stable(status));
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done_stop, ev_done_nostop, ev_arb_lost, ev_bus_err}));
  p_stop_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_stop |-> $past(eng_op == OP_STOP && eng_done));
  p_arb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |-> (status[6:4] == 3'd3 && status[3:2] == 2'd3 && !eng_req));
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[19:9] <= len);
  p_berr_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |-> (!eng_req && status[6:4] == 3'd4));
endmodule

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [19:0] status;
  logic ev_done_stop, ev_done_nostop, ev_arb_lost, ev_bus_err;
  logic [7:0] wr_data = 8'h00;
  logic wr_take, rx_valid, eng_req, eng_ack_out;
  logic [7:0] rx_data, eng_wdata;
  logic [1:0] eng_op;
  logic eng_done = 1'b0, eng_rx_ack = 1'b0, eng_arb_lost = 1'b0, eng_bus_err = 1'b0;
  logic [7:0] eng_rdata = 8'h00;

  i2c_cmd_seq i_i2c_cmd_seq (.*);

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int nlog = 0, nrx = 0, ntake = 0, wait_cnt = 0, arb_idx = -1;
  int n_dstop = 0, n_dnostop = 0, n_arb = 0, n_berr = 0;
  logic [1:0] log_op [64];
  logic [7:0] log_wd [64];
  logic       log_ack [64];
  logic [7:0] rxlog [64];
  logic       ack_map [64];

  always @(negedge clk) begin
    cyc++;
    if (rx_valid && nrx < 64) begin rxlog[nrx] = rx_data; nrx++; end
    if (wr_take) ntake++;
    if (ev_done_stop) n_dstop++;
    if (ev_done_nostop) n_dnostop++;
    if (ev_arb_lost) n_arb++;
    if (ev_bus_err) n_berr++;
    eng_done = 1'b0;
    eng_arb_lost = 1'b0;
    if (eng_req && nlog < 64) begin
      if (wait_cnt == 1) begin
        eng_done = 1'b1;
        eng_rx_ack = ack_map[nlog];
        eng_arb_lost = (nlog == arb_idx);
        eng_rdata = 8'h40 + 8'(nlog);
        log_op[nlog] = eng_op;
        log_wd[nlog] = eng_wdata;
        log_ack[nlog] = eng_ack_out;
        nlog++;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
    wr_data = 8'hC0 + 8'(nlog);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic dir, input logic [9:0] a, input logic ten,
                                     input logic sb, input logic stp, input logic [10:0] len);
    return {6'd0, len, stp, (ten ? 2'd2 : 2'd1), sb, a[9:7], a[6:0], dir};
  endfunction

  task automatic clear();
    @(negedge clk);
    nlog = 0; nrx = 0; ntake = 0; arb_idx = -1;
    n_dstop = 0; n_dnostop = 0; n_arb = 0; n_berr = 0;
    for (int k = 0; k < 64; k++) ack_map[k] = 1'b1;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic finish_wait(input string tag);
    int t = 0;
    while (status[3:2] == 2'd1 && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) begin nchk++; nerr++; $display("FAIL %s timeout act=busy exp=done", tag); end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 32'h3);
    chk("R1 req", 32'(eng_req), 0);
  endtask

  task automatic t_write7();
    clear();
    issue(mk(1'b0, 10'h02A, 1'b0, 1'b0, 1'b1, 11'd3));
    finish_wait("R2");
    chk("R2 nops", nlog, 6);
    chk("R2 start", 32'(log_op[0]), 0);
    chk("R2 addr", 32'(log_wd[1]), 32'h54);
    for (int k = 2; k < 5; k++) begin
      chk("R2 dop", 32'(log_op[k]), 1);
      chk("R2 dbyte", 32'(log_wd[k]), 32'hC0 + k);
    end
    chk("R2 take", ntake, 3);
    chk("R2 count", 32'(status[19:9]), 3);
    chk("R5 stop op", 32'(log_op[5]), 3);
    chk("R5 state", 32'(status[3:2]), 2);
    chk("R5 op", 32'(status[1:0]), 0);
    chk("R5 ev", n_dstop, 1);
  endtask

  task automatic t_read10();
    clear();
    issue(mk(1'b1, 10'h2B5, 1'b1, 1'b0, 1'b0, 11'd2));
    finish_wait("R3");
    chk("R6 nops", nlog, 5);
    chk("R3 byte1", 32'(log_wd[1]), 32'hF5);
    chk("R3 byte2", 32'(log_wd[2]), 32'hB5);
    chk("R4 rdop", 32'(log_op[3]), 2);
    chk("R4 ack first", 32'(log_ack[3]), 1);
    chk("R4 nack last", 32'(log_ack[4]), 0);
    chk("R4 nrx", nrx, 2);
    chk("R4 rx0", 32'(rxlog[0]), 32'h43);
    chk("R4 rx1", 32'(rxlog[1]), 32'h44);
    chk("R6 ev", n_dnostop, 1);
    chk("R6 noev stop", n_dstop, 0);
    chk("R6 state", 32'(status[3:2]), 2);
    chk("R6 op", 32'(status[1:0]), 1);
    chk("R6 count", 32'(status[19:9]), 2);
  endtask

  task automatic t_restart();
    clear();
    issue(mk(1'b0, 10'h011, 1'b0, 1'b0, 1'b1, 11'd1));
    finish_wait("R6b");
    chk("R6 restart op", 32'(log_op[0]), 0);
    chk("R6 restart addr", 32'(log_wd[1]), 32'h22);
  endtask

  task automatic t_nack_addr();
    clear();
    ack_map[1] = 1'b0;
    issue(mk(1'b0, 10'h030, 1'b0, 1'b0, 1'b1, 11'd2));
    finish_wait("R7a");
    chk("R7 addr nops", nlog, 3);
    chk("R7 addr stop", 32'(log_op[2]), 3);
    chk("R7 addr cause", 32'(status[6:4]), 0);
    chk("R7 addr state", 32'(status[3:2]), 3);
    chk("R7 addr noev", n_dstop + n_dnostop, 0);
  endtask

  task automatic t_nack_data();
    clear();
    ack_map[3] = 1'b0;
    issue(mk(1'b0, 10'h030, 1'b0, 1'b0, 1'b1, 11'd4));
    finish_wait("R7d");
    chk("R7 data nops", nlog, 5);
    chk("R7 data stop", 32'(log_op[4]), 3);
    chk("R7 data cause", 32'(status[6:4]), 1);
    chk("R7 data count", 32'(status[19:9]), 1);
    chk("R7 data state", 32'(status[3:2]), 3);
  endtask

  task automatic t_startbyte();
    clear();
    ack_map[1] = 1'b0;
    issue(mk(1'b0, 10'h055, 1'b0, 1'b1, 1'b1, 11'd1));
    finish_wait("R8a");
    chk("R8 nops", nlog, 6);
    chk("R8 mcode", 32'(log_wd[1]), 32'h01);
    chk("R8 restart", 32'(log_op[2]), 0);
    chk("R8 addr", 32'(log_wd[3]), 32'hAA);
    chk("R8 state", 32'(status[3:2]), 2);
    clear();
    issue(mk(1'b0, 10'h055, 1'b0, 1'b1, 1'b1, 11'd1));
    finish_wait("R8b");
    chk("R8 ack nops", nlog, 3);
    chk("R8 ack stop", 32'(log_op[2]), 3);
    chk("R8 ack cause", 32'(status[6:4]), 2);
    chk("R8 ack state", 32'(status[3:2]), 3);
  endtask

  task automatic t_arb();
    clear();
    arb_idx = 2;
    issue(mk(1'b0, 10'h013, 1'b0, 1'b0, 1'b1, 11'd3));
    finish_wait("R9");
    repeat (10) @(negedge clk);
    chk("R9 nops", nlog, 3);
    chk("R9 cause", 32'(status[6:4]), 3);
    chk("R9 state", 32'(status[3:2]), 3);
    chk("R9 ev", n_arb, 1);
    chk("R9 req", 32'(eng_req), 0);
  endtask

  task automatic t_berr();
    int t = 0;
    int snap;
    clear();
    issue(mk(1'b0, 10'h013, 1'b0, 1'b0, 1'b1, 11'd5));
    while (nlog < 2 && t < 200) begin @(negedge clk); t++; end
    @(negedge clk);
    eng_bus_err = 1'b1;
    @(negedge clk);
    eng_bus_err = 1'b0;
    snap = nlog;
    repeat (10) @(negedge clk);
    chk("R10 cause", 32'(status[6:4]), 4);
    chk("R10 state", 32'(status[3:2]), 3);
    chk("R10 ev", n_berr, 1);
    chk("R10 req", 32'(eng_req), 0);
    chk("R10 no more ops", nlog, snap);
  endtask

  task automatic t_overflow();
    clear();
    issue(mk(1'b0, 10'h013, 1'b0, 1'b0, 1'b1, 11'd5) | 32'h0400_0000);
    repeat (6) @(negedge clk);
    chk("R11 cause", 32'(status[6:4]), 6);
    chk("R11 state", 32'(status[3:2]), 3);
    chk("R11 nops", nlog, 0);
  endtask

  task automatic t_busy();
    clear();
    issue(mk(1'b0, 10'h021, 1'b0, 1'b0, 1'b1, 11'd4));
    issue(mk(1'b1, 10'h07F, 1'b0, 1'b0, 1'b0, 11'd1));
    finish_wait("R12");
    chk("R12 addr", 32'(log_wd[1]), 32'h42);
    chk("R12 op", 32'(status[1:0]), 0);
    chk("R12 count", 32'(status[19:9]), 4);
    chk("R12 nops", nlog, 7);
    chk("R12 ev", n_dstop + n_dnostop, 1);
  endtask

  task automatic t_zero();
    clear();
    issue(mk(1'b0, 10'h044, 1'b0, 1'b0, 1'b1, 11'd0));
    finish_wait("R13");
    chk("R13 nops", nlog, 3);
    chk("R13 stop", 32'(log_op[2]), 3);
    chk("R13 state", 32'(status[3:2]), 2);
    chk("R13 count", 32'(status[19:9]), 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) ack_map[k] = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write7();
    t_read10();
    t_restart();
    t_nack_addr();
    t_nack_data();
    t_startbyte();
    t_arb();
    t_berr();
    t_overflow();
    t_busy();
    t_zero();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1500000;
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule